// File: doc/BRIEF.md
# Packet-Scheduled FIFO Transfer Controller

This block moves fixed-length packets between memory and two external FIFOs. Receive-side packets are read from a receive FIFO into memory. Transmit-side packets are written from memory into a transmit FIFO. One transfer engine is shared by both directions. It loads a down-counter with the packet length and issues one memory access and one FIFO strobe per cycle. No per-word handshake is used. The FIFO side needs no address. The memory address steps up or down after each word.

Receive work comes from a level flag that means "a whole packet is waiting", together with the memory address that the packet should land at. The flag acts as a hardware trigger that can be armed and disarmed. When a packet is accepted, the trigger is disarmed. If the engine is busy at that moment, the address is parked in a one-entry read slot; the address value zero marks that slot empty. Transmit work comes from a request port that carries the memory source address. The request is parked in a one-entry write slot. A write starts only while the transmit FIFO reports room for a full packet.

At terminal count the controller raises a one-cycle interrupt and picks the next job. A parked read comes first. If no read is parked, it polls the receive flag. After that comes a parked write that has room. If there is nothing to do, it re-arms the receive trigger.

Top module: `pktdma_top`

## Requirements
- R1: After reset, memReq, rxFifoRd, txFifoWr, doneIrq and wrBusy are all 0, and the receive trigger is armed.
- R2: While idle with the trigger armed and rxPktReady high, a read transfer starts at the next clock edge. In the cycle after that edge, memReq=1, memWrite=1 and rxFifoRd=1, and memAddr equals the rxDstAddr value sampled at that edge.
- R3: Each transfer lasts exactly PKT_WORDS consecutive cycles. In each of those cycles memReq is high and exactly one FIFO strobe is high: rxFifoRd for a read, txFifoWr for a write.
- R4: stepDown is sampled when a transfer starts. A value of 0 makes memAddr rise by 1 per word; a value of 1 makes it fall by 1. Changes to stepDown during a transfer have no effect on that transfer.
- R5: doneIrq is high for exactly one cycle, which is the cycle right after the last word of a transfer.
- R6: If rxPktReady is high while a transfer is running and the trigger is armed, rxDstAddr is stored in the read slot and no transfer starts. The trigger is then disarmed. An address of 0 means the slot is empty.
- R7: At terminal count, a parked read is started before a parked write. The next transfer begins in the cycle right after the last word, using the parked address and not the current rxDstAddr.
- R8: Once the trigger is disarmed, rxPktReady does not load the read slot. At terminal count with the read slot empty, rxPktReady is polled, and if it is high a read starts at the current rxDstAddr.
- R9: A write transfer never starts unless txSpaceOk was high at the edge where it starts. A parked write waits while txSpaceOk is low.
- R10: A wrReq pulse is stored in the write slot if the slot is empty. wrBusy is high while the slot holds a request. A wrReq pulse that arrives while the slot is full is dropped, and the parked address is kept.
- R11: If terminal count finds no read and no startable write, the trigger is re-armed. A later rxPktReady then starts a read from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxPktReady | input | 1 | Receive FIFO holds at least one full packet |
| rxDstAddr | input | ADDR_W | Memory destination for the next receive packet (0 is not allowed) |
| txSpaceOk | input | 1 | Transmit FIFO has room for a full packet |
| wrReq | input | 1 | One-cycle request to send a packet from memory |
| wrSrcAddr | input | ADDR_W | Memory source address for wrReq (0 is not allowed) |
| wrBusy | output | 1 | Write slot full; a new wrReq is dropped |
| stepDown | input | 1 | 0: memory address increments, 1: decrements |
| memReq | output | 1 | Memory access this cycle |
| memWrite | output | 1 | 1: memory write (receive), 0: memory read (transmit) |
| memAddr | output | ADDR_W | Memory word address |
| rxFifoRd | output | 1 | Read strobe to the receive FIFO |
| txFifoWr | output | 1 | Write strobe to the transmit FIFO |
| doneIrq | output | 1 | One-cycle completion interrupt |

## Verification
Three things can happen in the same cycle: the last word of one transfer, the completion interrupt of that transfer, and the first word of the next transfer, whose address comes from a parked slot or from a polled flag. The bench sets this up in two ways. First, it parks both a read and a write during a running transfer, then moves rxDstAddr before terminal count. Second, it keeps the receive flag high across a read while changing rxDstAddr. At the cycle after the last word, it judges the interrupt, the direction and the start address together against the priority order. It also checks that the following transfer starts back to back.

// File: rtl/pktdma_pkg.sv
package pktdma_pkg;
  typedef enum logic [1:0] {
    SEL_RDSLOT = 2'd0,
    SEL_RXDST  = 2'd1,
    SEL_WSLOT  = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic    start;
    logic    dirRx;
    srcSel_e sel;
    logic    loadRdSlot;
    logic    clrRdSlot;
    logic    loadWs;
    logic    clrWs;
  } dpCmd_t;
endpackage

// File: rtl/pktdma_ctrl.sv
module pktdma_ctrl
  import pktdma_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxPktReady,
  input  logic   txSpaceOk,
  input  logic   wrReq,
  input  logic   busy,
  input  logic   lastWord,
  input  logic   rdSlotFull,
  input  logic   wsValid,
  output dpCmd_t cmd
);
  logic trigEn;
  logic trigNext;

  always_comb begin
    cmd      = '0;
    trigNext = trigEn;
    cmd.loadWs = wrReq && !wsValid;
    if (lastWord) begin
      if (rdSlotFull) begin
        cmd.start     = 1'b1;
        cmd.dirRx     = 1'b1;
        cmd.sel       = SEL_RDSLOT;
        cmd.clrRdSlot = 1'b1;
        trigNext      = 1'b0;
      end else if (rxPktReady) begin
        cmd.start = 1'b1;
        cmd.dirRx = 1'b1;
        cmd.sel   = SEL_RXDST;
        trigNext  = 1'b0;
      end else if (wsValid && txSpaceOk) begin
        cmd.start = 1'b1;
        cmd.dirRx = 1'b0;
        cmd.sel   = SEL_WSLOT;
        cmd.clrWs = 1'b1;
        trigNext  = 1'b0;
      end else begin
        trigNext = 1'b1;
      end
    end else if (!busy) begin
      if (trigEn && rxPktReady) begin
        cmd.start = 1'b1;
        cmd.dirRx = 1'b1;
        cmd.sel   = SEL_RXDST;
        trigNext  = 1'b0;
      end else if (wsValid && txSpaceOk) begin
        cmd.start = 1'b1;
        cmd.dirRx = 1'b0;
        cmd.sel   = SEL_WSLOT;
        cmd.clrWs = 1'b1;
      end
    end else begin
      if (trigEn && rxPktReady && !rdSlotFull) begin
        cmd.loadRdSlot = 1'b1;
        trigNext       = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) trigEn <= 1'b1;
    else       trigEn <= trigNext;
  end

  // R8
  trig_off_when_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSlotFull |-> !trigEn);

  // R11
  idle_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(busy) && $past(rstN)) |-> trigEn);
endmodule

// File: rtl/pktdma_dp.sv
module pktdma_dp
  import pktdma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PKT_WORDS = 4,
  parameter logic [ADDR_W-1:0] NULL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] rxDstAddr,
  input  logic [ADDR_W-1:0] wrSrcAddr,
  input  logic              stepDown,
  output logic              busy,
  output logic              lastWord,
  output logic              rdSlotFull,
  output logic              wsValid,
  output logic              dirRx,
  output logic [ADDR_W-1:0] memAddr,
  output logic              doneIrq
);
  localparam int CNT_W = $clog2(PKT_WORDS + 1);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] startAddr;
  logic [ADDR_W-1:0] rdSlot;
  logic [ADDR_W-1:0] wsAddr;
  logic              stepDnQ;
  logic              wsValidQ;
  logic              doneQ;

  assign busy       = (cnt != '0);
  assign lastWord   = (cnt == CNT_W'(1));
  assign rdSlotFull = (rdSlot != NULL_ADDR);
  assign wsValid    = wsValidQ;
  assign memAddr    = curAddr;
  assign doneIrq    = doneQ;

  always_comb begin
    case (cmd.sel)
      SEL_RDSLOT: startAddr = rdSlot;
      SEL_WSLOT:  startAddr = wsAddr;
      default:    startAddr = rxDstAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      curAddr <= '0;
      dirRx   <= 1'b0;
      stepDnQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= lastWord;
      if (cmd.start) begin
        cnt     <= CNT_W'(PKT_WORDS);
        curAddr <= startAddr;
        dirRx   <= cmd.dirRx;
        stepDnQ <= stepDown;
      end else if (busy) begin
        cnt     <= cnt - CNT_W'(1);
        curAddr <= stepDnQ ? curAddr - ADDR_W'(1) : curAddr + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSlot   <= NULL_ADDR;
      wsAddr   <= '0;
      wsValidQ <= 1'b0;
    end else begin
      if (cmd.loadRdSlot)     rdSlot <= rxDstAddr;
      else if (cmd.clrRdSlot) rdSlot <= NULL_ADDR;
      if (cmd.loadWs) begin
        wsAddr   <= wrSrcAddr;
        wsValidQ <= 1'b1;
      end else if (cmd.clrWs) begin
        wsValidQ <= 1'b0;
      end
    end
  end

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(lastWord)) |->
      (memAddr == (stepDnQ ? $past(curAddr) - ADDR_W'(1) : $past(curAddr) + ADDR_W'(1))));

  // R6
  slot_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSlotFull |-> busy);

  // R10
  ws_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wsValidQ && !cmd.clrWs) |=> (wsValidQ && $stable(wsAddr)));

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.start |-> (!busy || lastWord));
endmodule

// File: rtl/pktdma_top.sv
module pktdma_top
  import pktdma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PKT_WORDS = 4,
  parameter logic [ADDR_W-1:0] NULL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPktReady,
  input  logic [ADDR_W-1:0] rxDstAddr,
  input  logic              txSpaceOk,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrSrcAddr,
  output logic              wrBusy,
  input  logic              stepDown,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rxFifoRd,
  output logic              txFifoWr,
  output logic              doneIrq
);
  dpCmd_t cmd;
  logic   busy;
  logic   lastWord;
  logic   rdSlotFull;
  logic   wsValid;
  logic   dirRx;

  pktdma_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxPktReady(rxPktReady),
    .txSpaceOk (txSpaceOk),
    .wrReq     (wrReq),
    .busy      (busy),
    .lastWord  (lastWord),
    .rdSlotFull(rdSlotFull),
    .wsValid   (wsValid),
    .cmd       (cmd)
  );

  pktdma_dp #(
    .ADDR_W   (ADDR_W),
    .PKT_WORDS(PKT_WORDS),
    .NULL_ADDR(NULL_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .rxDstAddr (rxDstAddr),
    .wrSrcAddr (wrSrcAddr),
    .stepDown  (stepDown),
    .busy      (busy),
    .lastWord  (lastWord),
    .rdSlotFull(rdSlotFull),
    .wsValid   (wsValid),
    .dirRx     (dirRx),
    .memAddr   (memAddr),
    .doneIrq   (doneIrq)
  );

  assign memReq   = busy;
  assign memWrite = busy && dirRx;
  assign rxFifoRd = busy && dirRx;
  assign txFifoWr = busy && !dirRx;
  assign wrBusy   = wsValid;

  // R9
  tx_space_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txFifoWr && !$past(txFifoWr) && $past(rstN)) |-> $past(txSpaceOk));

  // R5
  done_after_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> $past(memReq));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> $onehot({rxFifoRd, txFifoWr}));
endmodule

// File: tb/pktdma_top_bench.sv
module pktdma_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxPktReady = 1'b0;
  logic [AW-1:0] rxDstAddr = '0;
  logic          txSpaceOk = 1'b0;
  logic          wrReq = 1'b0;
  logic [AW-1:0] wrSrcAddr = '0;
  logic          wrBusy;
  logic          stepDown = 1'b0;
  logic          memReq;
  logic          memWrite;
  logic [AW-1:0] memAddr;
  logic          rxFifoRd;
  logic          txFifoWr;
  logic          doneIrq;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktdma_top #(.ADDR_W(AW), .PKT_WORDS(PW)) u_pktdma_top (
    .clk(clk), .rstN(rstN), .rxPktReady(rxPktReady), .rxDstAddr(rxDstAddr),
    .txSpaceOk(txSpaceOk), .wrReq(wrReq), .wrSrcAddr(wrSrcAddr), .wrBusy(wrBusy),
    .stepDown(stepDown), .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .rxFifoRd(rxFifoRd), .txFifoWr(txFifoWr), .doneIrq(doneIrq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expectXfer(string tag, logic [AW-1:0] base, bit rx, bit down);
    for (int i = 0; i < PW; i++) begin
      if (i > 0) tick();
      chk({tag, " memReq"}, 32'(memReq), 32'd1);
      chk({tag, " memWrite"}, 32'(memWrite), 32'(rx));
      chk({tag, " rxFifoRd"}, 32'(rxFifoRd), 32'(rx));
      chk({tag, " txFifoWr"}, 32'(txFifoWr), 32'(!rx));
      chk({tag, " memAddr"}, 32'(memAddr),
          32'(down ? base - AW'(i) : base + AW'(i)));
    end
  endtask

  task automatic expectDoneIdle(string tag);
    tick();
    chk({tag, " doneIrq"}, 32'(doneIrq), 32'd1);
    chk({tag, " memReq idle"}, 32'(memReq), 32'd0);
    tick();
    chk({tag, " doneIrq drop"}, 32'(doneIrq), 32'd0);
  endtask

  task automatic testReset();
    chk("R1 memReq", 32'(memReq), 32'd0);
    chk("R1 rxFifoRd", 32'(rxFifoRd), 32'd0);
    chk("R1 txFifoWr", 32'(txFifoWr), 32'd0);
    chk("R1 doneIrq", 32'(doneIrq), 32'd0);
    chk("R1 wrBusy", 32'(wrBusy), 32'd0);
  endtask

  task automatic testIdleRead();
    rxPktReady = 1'b1; rxDstAddr = 16'h0100; stepDown = 1'b0;
    tick();
    rxPktReady = 1'b0; rxDstAddr = 16'h0EEE;
    expectXfer("R2 R3 read up", 16'h0100, 1'b1, 1'b0);
    expectDoneIdle("R5 read");
  endtask

  task automatic testWriteDown();
    txSpaceOk = 1'b1; stepDown = 1'b1; wrReq = 1'b1; wrSrcAddr = 16'h0200;
    tick();
    wrReq = 1'b0;
    tick();
    stepDown = 1'b0;
    expectXfer("R4 write down", 16'h0200, 1'b0, 1'b1);
    expectDoneIdle("R5 write");
  endtask

  task automatic testNoSpace();
    txSpaceOk = 1'b0; wrReq = 1'b1; wrSrcAddr = 16'h0250;
    tick();
    chk("R10 wrBusy set", 32'(wrBusy), 32'd1);
    wrSrcAddr = 16'h0260;
    tick();
    wrReq = 1'b0;
    tick();
    chk("R9 held memReq", 32'(memReq), 32'd0);
    chk("R10 wrBusy held", 32'(wrBusy), 32'd1);
    txSpaceOk = 1'b1;
    tick();
    expectXfer("R9 R10 write first addr", 16'h0250, 1'b0, 1'b0);
    chk("R10 wrBusy clear", 32'(wrBusy), 32'd0);
    expectDoneIdle("R9 write");
  endtask

  task automatic testPriority();
    txSpaceOk = 1'b1; wrReq = 1'b1; wrSrcAddr = 16'h0300;
    tick();
    wrReq = 1'b0;
    tick();
    chk("R7 write start", 32'(memAddr), 32'h0300);
    rxPktReady = 1'b1; rxDstAddr = 16'h0400; wrReq = 1'b1; wrSrcAddr = 16'h0600;
    tick();
    chk("R6 no start addr", 32'(memAddr), 32'h0301);
    chk("R6 no start dir", 32'(memWrite), 32'd0);
    chk("R10 wrBusy parked", 32'(wrBusy), 32'd1);
    rxPktReady = 1'b0; wrReq = 1'b0; rxDstAddr = 16'h0500;
    tick();
    tick();
    tick();
    chk("R7 done at chain", 32'(doneIrq), 32'd1);
    expectXfer("R7 parked read first", 16'h0400, 1'b1, 1'b0);
    tick();
    chk("R7 done at second chain", 32'(doneIrq), 32'd1);
    expectXfer("R7 parked write second", 16'h0600, 1'b0, 1'b0);
    expectDoneIdle("R7 chain end");
  endtask

  task automatic testPoll();
    rxPktReady = 1'b1; rxDstAddr = 16'h0700;
    tick();
    rxDstAddr = 16'h0800;
    expectXfer("R8 first read", 16'h0700, 1'b1, 1'b0);
    rxDstAddr = 16'h0900;
    tick();
    chk("R8 done at poll", 32'(doneIrq), 32'd1);
    rxPktReady = 1'b0;
    expectXfer("R8 polled read current addr", 16'h0900, 1'b1, 1'b0);
    expectDoneIdle("R8 poll end");
  endtask

  task automatic testRearm();
    tick();
    chk("R11 quiet", 32'(memReq), 32'd0);
    rxPktReady = 1'b1; rxDstAddr = 16'h0A00;
    tick();
    rxPktReady = 1'b0;
    expectXfer("R11 rearmed read", 16'h0A00, 1'b1, 1'b0);
    expectDoneIdle("R11 end");
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testIdleRead();
    testWriteDown();
    testNoSpace();
    testPriority();
    testPoll();
    testRearm();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule